// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block multiplies or divides two 32-bit integers, signed or unsigned. It works one bit per clock cycle and leaves the answer in a pair of 32-bit result registers, HI and LO. The controller gives a one-cycle start pulse together with an operation code and two operands. The unit then raises `busy` for a fixed number of cycles. When the result registers hold the new answer, it pulses `done` for one cycle. HI and LO can be read at any time and keep their value until the next operation finishes.

One 64-bit working register does both jobs. For a multiply it is a shift-add product register. For a divide it is a restoring remainder/quotient register. Signed operations work on operand magnitudes, and one final cycle applies the signs. The hardware does not report overflow or a zero divisor. A zero divisor produces the value that the iteration yields, which is stated below so software can rely on it.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 is a signed multiply. The 64-bit two's-complement product goes to {HI, LO}, with HI holding bits 63:32 and LO holding bits 31:0.
- R2: Operation code 2'b01 is an unsigned multiply. The 64-bit unsigned product goes to {HI, LO} in the same split as R1.
- R3: Operation code 2'b10 is a signed divide. LO receives the quotient, truncated toward zero, and HI receives the remainder, which has the sign of the dividend.
- R4: Operation code 2'b11 is an unsigned divide. LO receives the quotient and HI receives the remainder.
- R5: A zero divisor is not detected. An unsigned divide returns LO = 32'hFFFFFFFF and HI = dividend. A signed divide returns HI = dividend, with LO = -1 when the dividend is non-negative and LO = +1 when it is negative.
- R6: A start pulse is accepted only while `busy` is low. `busy` rises on the next clock edge and stays high for exactly 33 cycles.
- R7: `done` is high for exactly one cycle. It rises on the same edge on which `busy` falls, which is the 34th rising edge counting the edge that sampled start as the first.
- R8: A start pulse given while `busy` is high is ignored. It changes neither the running operation's result nor its timing, and it produces no extra `done`.
- R9: Reset clears HI, LO, `busy` and `done` to zero. HI and LO change only on the edge that raises `done`, and they keep the previous result while an operation runs.
- R10: Extreme operands wrap without any error. The signed divide -2^31 / -1 gives LO = 32'h80000000 and HI = 0. The signed multiply (-2^31) x (-2^31) gives HI = 32'h40000000 and LO = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation code: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplier, or dividend |
| opb | input | 32 | Multiplicand, or divisor |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle pulse when HI/LO have just been written |
| hi | output | 32 | Upper product half, or remainder |
| lo | output | 32 | Lower product half, or quotient |

## Verification
Every operation has the same latency. The edge that samples start is followed by 32 iteration edges and one sign-fixup edge. `done` and the new HI/LO therefore appear after the 34th edge, and `busy` covers the 33 cycles in between. The bench stamps each request with the cycle count at the moment start is driven. The monitor reads `done`, HI and LO half a cycle after each edge, then compares both the values and the elapsed cycle count with the queued expectation. The hold and ignored-start checks sample the result registers in the middle of a run and in the quiet cycles after `done`, so that stray writes would be seen at the ports.

// File: rtl/muldiv_pkg.sv
// Shared encodings for the iterative multiply/divide unit.
package muldiv_pkg;

    // Operation codes: bit 1 selects divide, bit 0 selects unsigned.
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ITER = 2'b01,
        ST_SIGN = 2'b10
    } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
// Sequencer for the iterative multiply/divide unit.
// Accepts a start request only while idle. It then runs XLEN iteration
// cycles followed by one sign-fixup cycle, and pulses done after that.
// Assumes start is a level sampled on each rising edge. While the unit is
// not idle, start is ignored.
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);

    localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;
    localparam logic [CW-1:0] LAST_ITER = CW'(XLEN - 1);

    md_state_e     state_q;
    logic [CW-1:0] iter_q;
    logic          done_q;

    // Decode the strobes that drive the datapath.
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_ITER);
        fix  = (state_q == ST_SIGN);
        busy = (state_q != ST_IDLE);
    end

    // State and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    iter_q <= '0;
                    if (start) state_q <= ST_ITER;
                end
                ST_ITER: begin
                    iter_q <= iter_q + 1'b1;
                    if (iter_q == LAST_ITER) state_q <= ST_SIGN;
                end
                ST_SIGN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse, aligned with the result register write.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= fix;
    end

    assign done = done_q;

endmodule

// File: rtl/muldiv_core.sv
// Shared working register for shift-add multiply and restoring divide.
// On load it captures the operand magnitudes and the sign flags for the
// result. On each step it performs one partial-product addition or one
// partial-remainder subtraction. Assumes load and step are never high in
// the same cycle.
module muldiv_core #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              is_div_i,
    input  logic              is_signed_i,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic [2*XLEN-1:0] acc_o,
    output logic              is_div_o,
    output logic              neg_lo_o,
    output logic              neg_hi_o
);

    localparam int AW = 2 * XLEN;

    logic [AW-1:0]   acc_q;
    logic [XLEN-1:0] opnd_q;
    logic            is_div_q;
    logic            neg_lo_q;
    logic            neg_hi_q;

    logic            sign_a;
    logic            sign_b;
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;
    logic [AW-1:0]   mul_next;
    logic [AW-1:0]   div_next;
    logic [XLEN:0]   mul_sum;
    logic [XLEN+1:0] div_trial;

    // Operand signs and magnitudes. Unsigned operands pass straight through.
    always_comb begin
        sign_a = is_signed_i && opa[XLEN-1];
        sign_b = is_signed_i && opb[XLEN-1];
        mag_a  = sign_a ? (~opa + XLEN'(1)) : opa;
        mag_b  = sign_b ? (~opb + XLEN'(1)) : opb;
    end

    // One multiply step: add the multiplicand to the upper half when the
    // low bit is set, then shift the whole register right by one.
    always_comb begin
        mul_sum  = {1'b0, acc_q[AW-1:XLEN]} + (acc_q[0] ? {1'b0, opnd_q} : '0);
        mul_next = {mul_sum, acc_q[XLEN-1:1]};
    end

    // One restoring divide step: shift left, then try to subtract the divisor.
    // A negative trial keeps the shifted remainder and leaves quotient bit 0.
    always_comb begin
        div_trial = {1'b0, acc_q[AW-1:XLEN-1]} - {2'b00, opnd_q};
        if (div_trial[XLEN+1]) div_next = {acc_q[AW-2:0], 1'b0};
        else                   div_next = {div_trial[XLEN-1:0], acc_q[XLEN-2:0], 1'b1};
    end

    // Working register and captured operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            opnd_q <= '0;
        end else if (load) begin
            acc_q  <= {{XLEN{1'b0}}, mag_a};
            opnd_q <= mag_b;
        end else if (step) begin
            acc_q  <= is_div_q ? div_next : mul_next;
        end
    end

    // Operation kind and the result sign flags for the fixup stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_div_q <= 1'b0;
            neg_lo_q <= 1'b0;
            neg_hi_q <= 1'b0;
        end else if (load) begin
            is_div_q <= is_div_i;
            neg_lo_q <= sign_a ^ sign_b;
            neg_hi_q <= is_div_i ? sign_a : (sign_a ^ sign_b);
        end
    end

    assign acc_o    = acc_q;
    assign is_div_o = is_div_q;
    assign neg_lo_o = neg_lo_q;
    assign neg_hi_o = neg_hi_q;

endmodule

// File: rtl/muldiv_fixup.sv
// Sign correction of the raw magnitude result.
// A multiply negates the whole double-width product. A divide negates the
// quotient and the remainder independently. Purely combinational; assumes
// the inputs are stable in the fixup cycle.
module muldiv_fixup #(
    parameter int XLEN = 32
) (
    input  logic [2*XLEN-1:0] acc_i,
    input  logic              is_div_i,
    input  logic              neg_lo_i,
    input  logic              neg_hi_i,
    output logic [XLEN-1:0]   hi_o,
    output logic [XLEN-1:0]   lo_o
);

    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   quo;
    logic [XLEN-1:0]   rem;

    // Sign-corrected candidates for both operation kinds.
    always_comb begin
        prod = neg_lo_i ? (~acc_i + (2*XLEN)'(1)) : acc_i;
        quo  = neg_lo_i ? (~acc_i[XLEN-1:0] + XLEN'(1)) : acc_i[XLEN-1:0];
        rem  = neg_hi_i ? (~acc_i[2*XLEN-1:XLEN] + XLEN'(1)) : acc_i[2*XLEN-1:XLEN];
    end

    // Route the corrected halves to the result registers.
    always_comb begin
        if (is_div_i) begin
            hi_o = rem;
            lo_o = quo;
        end else begin
            hi_o = prod[2*XLEN-1:XLEN];
            lo_o = prod[XLEN-1:0];
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
// Iterative multiply/divide unit with HI/LO result registers.
// Operation codes come from muldiv_pkg. HI/LO are written only in the
// sign-fixup cycle and are readable at all times. Assumes start is driven
// synchronously. A zero divisor is not detected.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo
);

    logic              load;
    logic              step;
    logic              fix;
    logic [2*XLEN-1:0] acc;
    logic              is_div;
    logic              neg_lo;
    logic              neg_hi;
    logic [XLEN-1:0]   hi_fix;
    logic [XLEN-1:0]   lo_fix;
    logic [XLEN-1:0]   hi_q;
    logic [XLEN-1:0]   lo_q;
    md_op_e            op_e;

    assign op_e = md_op_e'(op);

    muldiv_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy),
        .done  (done)
    );

    muldiv_core #(.XLEN(XLEN)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .is_div_i    (op_e == OP_DIV_S || op_e == OP_DIV_U),
        .is_signed_i (op_e == OP_MUL_S || op_e == OP_DIV_S),
        .opa         (opa),
        .opb         (opb),
        .acc_o       (acc),
        .is_div_o    (is_div),
        .neg_lo_o    (neg_lo),
        .neg_hi_o    (neg_hi)
    );

    muldiv_fixup #(.XLEN(XLEN)) u_fixup (
        .acc_i    (acc),
        .is_div_i (is_div),
        .neg_lo_i (neg_lo),
        .neg_hi_i (neg_hi),
        .hi_o     (hi_fix),
        .lo_o     (lo_fix)
    );

    // Result registers, written once per operation in the fixup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (fix) begin
            hi_q <= hi_fix;
            lo_q <= lo_fix;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/muldiv_checker.sv
// Protocol checks for muldiv_unit, attached through bind.
// Observes only the ports. A counter measures the length of each busy span
// so that the check needs no deep $past.
module muldiv_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] hi,
    input logic [XLEN-1:0] lo
);

    localparam int RW = $clog2(XLEN + 2) + 1;
    localparam logic [RW-1:0] SPAN = RW'(XLEN + 1);

    logic [RW-1:0] span_q;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    span_q <= '0;
        else if (busy) span_q <= span_q + 1'b1;
        else           span_q <= '0;
    end

    // R6: an idle start is taken on the next edge.
    assert_start_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6, R8: every busy span lasts exactly XLEN+1 cycles.
    assert_busy_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (span_q == SPAN));

    // R7: done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done coincides with the end of busy.
    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: done never overlaps busy.
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: results move only with done.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo)));

endmodule

bind muldiv_unit muldiv_checker #(.XLEN(XLEN)) u_muldiv_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo)
);

// File: tb/muldiv_unit_bench.sv
// Scoreboard bench for muldiv_unit.
module muldiv_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int LATENCY    = XLEN + 2;
    localparam int WATCHDOG   = 20000;

    logic            clk;
    logic            rst_n;
    logic            start;
    logic [1:0]      op;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic            busy;
    logic            done;
    logic [XLEN-1:0] hi;
    logic [XLEN-1:0] lo;

    int checks;
    int errors;
    int cyc;
    bit finished;

    logic [31:0] last_hi;
    logic [31:0] last_lo;

    typedef struct {
        string       tag;
        logic [31:0] exp_hi;
        logic [31:0] exp_lo;
        int          issued;
    } sb_item_t;

    sb_item_t sb_q[$];

    muldiv_unit #(.XLEN(XLEN)) u_muldiv_unit (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .op    (op),
        .opa   (opa),
        .opb   (opb),
        .busy  (busy),
        .done  (done),
        .hi    (hi),
        .lo    (lo)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected HI/LO from the requirement text.
    task automatic model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] eh, output logic [31:0] el);
        logic [63:0] p;
        longint      sa;
        longint      sb;
        longint      q;
        longint      r;
        case (o)
            2'b00: begin
                p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
                eh = p[63:32]; el = p[31:0];
            end
            2'b01: begin
                p = {32'b0, a} * {32'b0, b};
                eh = p[63:32]; el = p[31:0];
            end
            2'b10: begin
                sa = longint'($signed(a));
                sb = longint'($signed(b));
                if (b == 0) begin
                    eh = a;
                    el = a[31] ? 32'd1 : 32'hFFFFFFFF;
                end else begin
                    q = sa / sb; r = sa % sb;
                    eh = r[31:0]; el = q[31:0];
                end
            end
            default: begin
                if (b == 0) begin
                    eh = a; el = 32'hFFFFFFFF;
                end else begin
                    eh = a % b; el = a / b;
                end
            end
        endcase
    endtask

    // Driver: pushes the expectation, pulses start and waits for completion.
    // mid_hold samples HI/LO during the run; intrude pulses a stray start.
    task automatic run_op(input string tag, input logic [1:0] o,
                          input logic [31:0] a, input logic [31:0] b,
                          input bit mid_hold, input bit intrude);
        sb_item_t it;
        logic [31:0] eh;
        logic [31:0] el;
        model(o, a, b, eh, el);
        it.tag = tag; it.exp_hi = eh; it.exp_lo = el;
        @(negedge clk);
        it.issued = cyc;
        sb_q.push_back(it);
        op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        if (intrude) begin
            op = ~o; opa = 32'h12345678; opb = 32'h3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (mid_hold) begin
            check("R9", "hi held mid-run", hi, last_hi);
            check("R9", "lo held mid-run", lo, last_lo);
        end
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
        check("R7", "done low after pulse", {31'b0, done}, 32'd0);
        if (intrude) begin
            repeat (40) begin
                @(negedge clk);
                if (done || busy) begin
                    check("R8", "no extra run", {30'b0, busy, done}, 32'd0);
                    break;
                end
            end
            check("R8", "hi unchanged after stray start", hi, eh);
            check("R8", "lo unchanged after stray start", lo, el);
        end
        last_hi = eh; last_lo = el;
    endtask

    // Monitor: compares each completion with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check("R8", "unexpected done", 32'd1, 32'd0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, "hi", hi, it.exp_hi);
                check(it.tag, "lo", lo, it.exp_lo);
                check("R6", "latency", 32'(cyc - it.issued), 32'(LATENCY));
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
            finish_run();
        end
    end

    initial begin
        checks = 0; errors = 0; cyc = 0; finished = 1'b0;
        rst_n = 1'b0; start = 1'b0; op = 2'b00; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset hi", hi, 32'd0);
        check("R9", "reset lo", lo, 32'd0);
        check("R9", "reset busy/done", {30'b0, busy, done}, 32'd0);
        last_hi = 32'd0; last_lo = 32'd0;

        run_op("R1", 2'b00, 32'd7, 32'd6, 1'b1, 1'b0);
        run_op("R1", 2'b00, 32'hFFFFFFFB, 32'd3, 1'b1, 1'b0);
        run_op("R1", 2'b00, 32'hFFFF0000, 32'hFFFF0000, 1'b0, 1'b0);
        run_op("R2", 2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b0);
        run_op("R2", 2'b01, 32'h80000000, 32'd2, 1'b0, 1'b0);
        run_op("R3", 2'b10, 32'hFFFFFFF9, 32'd2, 1'b1, 1'b0);
        run_op("R3", 2'b10, 32'd7, 32'hFFFFFFFE, 1'b0, 1'b0);
        run_op("R3", 2'b10, 32'hFFFFFFF9, 32'hFFFFFFFE, 1'b0, 1'b0);
        run_op("R4", 2'b11, 32'd100, 32'd7, 1'b1, 1'b0);
        run_op("R4", 2'b11, 32'hFFFFFFFF, 32'd3, 1'b0, 1'b0);
        run_op("R4", 2'b11, 32'd5, 32'd9, 1'b0, 1'b0);
        run_op("R5", 2'b11, 32'd5, 32'd0, 1'b0, 1'b0);
        run_op("R5", 2'b10, 32'hFFFFFFF7, 32'd0, 1'b0, 1'b0);
        run_op("R5", 2'b10, 32'd9, 32'd0, 1'b0, 1'b0);
        run_op("R10", 2'b10, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0);
        run_op("R10", 2'b00, 32'h80000000, 32'h80000000, 1'b0, 1'b0);
        run_op("R8", 2'b01, 32'd1000, 32'd1000, 1'b1, 1'b1);
        run_op("R8", 2'b10, 32'd12345, 32'd10, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        check("R6", "scoreboard drained", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule